// File: doc/BRIEF.md
# Grouped Interrupt Combiner Bank

This block folds a wide vector of level-sensitive interrupt lines into a smaller set of group interrupts for an upstream interrupt controller. Lines are gathered eight at a time into groups. Each group has one output. That output is high while at least one line of the group is high and enabled.

Four neighbouring groups share one bank of 32-bit registers, and each group uses one byte lane of that bank. Software changes the enable mask only through two write-one strobes. A write to the set register turns enables on, and a write to the clear register turns them off. Bits written as zero leave the mask unchanged. A status register shows which lines are currently pending and enabled.

The register port is single-cycle. A write commits at the clock edge where `we_i` is high. Read data is a combinational function of the address and the current state.

Top module: `irq_comb_top`

## Requirements
- R1: After reset, every enable bit is 0, every group output is 0, and the set, clear and status registers of every bank read 0, whatever levels the inputs have.
- R2: Input n belongs to group n/8 at bit n%8. Group g sits in bank g/4 at bits [8*(g%4)+7 : 8*(g%4)]. Bank b starts at byte address 0x10*b. Banks and groups are independent of each other.
- R3: A write to bank offset 0x0 sets every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A write to bank offset 0x4 clears every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R5: A read of bank offset 0xC returns the raw input levels ANDed with the enable bits, for all four byte lanes of that bank.
- R6: Group output g equals the OR of its eight enabled inputs, sampled at the previous clock edge. It is therefore delayed by exactly one cycle after a change of input or enable.
- R7: Inputs are level-sensitive. A group output stays high for as long as an enabled input of its group stays high, and it falls one cycle after the last such input is lowered or masked.
- R8: A read of offset 0x0 or of offset 0x4 returns the current enable mask of the bank.
- R9: Writes to offset 0xC, writes to offset 0x8 and writes to banks that do not exist change no state. Reads of offset 0x8, and reads of any address of a bank that does not exist, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_GROUPS*8 (160) | Level-sensitive interrupt lines |
| addr_i | input | ADDR_W (8) | Byte address of the register access |
| we_i | input | 1 | Write strobe, committed at the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| grp_irq_o | output | NUM_GROUPS (20) | One registered interrupt per group |

## Verification
The bench builds up enable masks with several set writes and partial clear writes. A design that overwrote the mask instead of applying write-one semantics would lose bits that had already been set.

The bench writes all-ones to the status offset, to the unused offset 0x8, and to the clear offset of an empty bank. A decoder that aliased any of these offsets onto set or clear would change a mask that the bench reads back afterwards.

The bench checks the timing of the group outputs on the exact cycle. It lowers an input, raises an input and masks an enabled line during a write, and looks at the output before and after the next clock edge. A combinational output, or an output with two register stages, would show its edge one cycle early or one cycle late.

The bench also checks the following:
- One line is mapped into bank 2, lane 1. A wrong group or lane mapping would light up the wrong output bit.
- Addresses beyond the last bank are read, and must return 0.
- Reset is applied while inputs are held high, and the enables must come back cleared.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int unsigned GRP_W       = 8;
  localparam int unsigned LANES       = 4;
  localparam int unsigned WORD_W      = GRP_W * LANES;
  localparam int unsigned OFF_W       = 4;
  localparam logic [OFF_W-1:0] OFF_SET  = 4'h0;
  localparam logic [OFF_W-1:0] OFF_CLR  = 4'h4;
  localparam logic [OFF_W-1:0] OFF_STAT = 4'hC;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_SET,
    ACC_CLR,
    ACC_STAT
  } acc_e;

  function automatic acc_e decode_off(logic [OFF_W-1:0] off);
    case (off)
      OFF_SET:  decode_off = ACC_SET;
      OFF_CLR:  decode_off = ACC_CLR;
      OFF_STAT: decode_off = ACC_STAT;
      default:  decode_off = ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_comb_decode.sv
module irq_comb_decode
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  output logic [NUM_BANKS-1:0] wr_set_o,
  output logic [NUM_BANKS-1:0] wr_clr_o,
  output logic [NUM_BANKS-1:0] bank_hit_o,
  output acc_e                 acc_o
);
  localparam int unsigned IDX_W = ADDR_W - OFF_W;

  logic [IDX_W-1:0] bank_idx;
  assign bank_idx = addr_i[ADDR_W-1:OFF_W];
  assign acc_o    = decode_off(addr_i[OFF_W-1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit_o[b] = (bank_idx == IDX_W'(b));
    assign wr_set_o[b]   = we_i && bank_hit_o[b] && (acc_o == ACC_SET);
    assign wr_clr_o[b]   = we_i && bank_hit_o[b] && (acc_o == ACC_CLR);
  end

  // at most one bank strobe per access: no cross-bank aliasing
  assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_set_o, wr_clr_o}));

  // status and unmapped offsets never produce a write strobe
  assert_no_stray_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o == ACC_STAT || acc_o == ACC_NONE) |-> ({wr_set_o, wr_clr_o} == '0));
endmodule

// File: rtl/irq_comb_group.sv
module irq_comb_group
  import irq_comb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] pend_i,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend_i;
  end

  assert_out_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|pend_i)));

  assert_level_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (|pend_i)) |=> irq_o);
endmodule

// File: rtl/irq_comb_bank.sv
module irq_comb_bank
  import irq_comb_pkg::*;
#(
  parameter int unsigned USED_LANES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WORD_W-1:0]     irq_i,
  input  logic                  wr_set_i,
  input  logic                  wr_clr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [WORD_W-1:0]     en_o,
  output logic [WORD_W-1:0]     stat_o,
  output logic [USED_LANES-1:0] grp_o
);
  localparam logic [WORD_W-1:0] LANE_MASK =
    (USED_LANES >= LANES) ? {WORD_W{1'b1}} :
                            WORD_W'((64'd1 << (GRP_W * USED_LANES)) - 64'd1);

  logic [WORD_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (wr_set_i) en_q <= (en_q | wdata_i) & LANE_MASK;
    else if (wr_clr_i) en_q <= en_q & ~wdata_i;
  end

  assign en_o   = en_q;
  assign stat_o = irq_i & en_q;

  for (genvar l = 0; l < USED_LANES; l++) begin : g_lane
    irq_comb_group u_grp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (stat_o[l*GRP_W +: GRP_W]),
      .irq_o  (grp_o[l])
    );
  end

  assert_set_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> ((en_q & $past(wdata_i) & LANE_MASK) == ($past(wdata_i) & LANE_MASK)));

  assert_set_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

  assert_clr_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> ((en_q & $past(wdata_i)) == '0));

  assert_clr_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

  assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set_i || wr_clr_i) |=> $stable(en_q));
endmodule

// File: rtl/irq_comb_top.sv
module irq_comb_top
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 20,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_GROUPS*GRP_W-1:0] irq_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [WORD_W-1:0]           rdata_o,
  output logic [NUM_GROUPS-1:0]       grp_irq_o
);
  localparam int unsigned NUM_IN    = NUM_GROUPS * GRP_W;
  localparam int unsigned NUM_BANKS = (NUM_GROUPS + LANES - 1) / LANES;
  localparam int unsigned PAD_W     = NUM_BANKS * WORD_W;
  localparam int unsigned LAST_LN   = NUM_GROUPS - LANES * (NUM_BANKS - 1);

  logic [PAD_W-1:0]     irq_pad;
  logic [NUM_BANKS-1:0] wr_set, wr_clr, bank_hit;
  acc_e                 acc;
  logic [WORD_W-1:0]    en_w   [NUM_BANKS];
  logic [WORD_W-1:0]    stat_w [NUM_BANKS];

  always_comb begin
    irq_pad = '0;
    irq_pad[NUM_IN-1:0] = irq_i;
  end

  irq_comb_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wr_set_o   (wr_set),
    .wr_clr_o   (wr_clr),
    .bank_hit_o (bank_hit),
    .acc_o      (acc)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned NL = (b == NUM_BANKS - 1) ? LAST_LN : LANES;
    irq_comb_bank #(
      .USED_LANES (NL)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .irq_i    (irq_pad[b*WORD_W +: WORD_W]),
      .wr_set_i (wr_set[b]),
      .wr_clr_i (wr_clr[b]),
      .wdata_i  (wdata_i),
      .en_o     (en_w[b]),
      .stat_o   (stat_w[b]),
      .grp_o    (grp_irq_o[b*LANES +: NL])
    );
  end

  // combinational read, single-cycle port
  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (acc)
          ACC_SET, ACC_CLR: rdata_o = en_w[b];
          ACC_STAT:         rdata_o = stat_w[b];
          default:          rdata_o = '0;
        endcase
      end
    end
  end

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc == ACC_NONE) || (bank_hit == '0)) |-> (rdata_o == '0));

  assert_set_clr_alias_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc == ACC_SET || acc == ACC_CLR) |-> ((rdata_o & ~en_w[0]) == '0 || !bank_hit[0]));
endmodule

// File: tb/irq_comb_top_tb_top.sv
`timescale 1ns/1ps
module irq_comb_top_tb_top;
  localparam int NG = 20;
  localparam int NI = NG * 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NI-1:0] irq_i = '0;
  logic [7:0]    addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NG-1:0] grp_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_comb_top #(.NUM_GROUPS(NG), .ADDR_W(8)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .grp_irq_o (grp_irq_o)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1, 8'h00, 32'h0,        32'h0},         // R1
    '{1'b0, 4'd1, 8'h0C, 32'h0,        32'h0},         // R1
    '{1'b1, 4'd3, 8'h00, 32'h0000FF0F, 32'h0},
    '{1'b0, 4'd3, 8'h00, 32'h0,        32'h0000FF0F},  // R3
    '{1'b0, 4'd5, 8'h0C, 32'h0,        32'h0000F00F},  // R5
    '{1'b1, 4'd3, 8'h00, 32'hFF000000, 32'h0},
    '{1'b0, 4'd8, 8'h04, 32'h0,        32'hFF00FF0F},  // R8, R3 accumulate
    '{1'b1, 4'd4, 8'h04, 32'h00000F0F, 32'h0},
    '{1'b0, 4'd4, 8'h00, 32'h0,        32'hFF00F000},  // R4
    '{1'b0, 4'd5, 8'h0C, 32'h0,        32'hA500F000},  // R5
    '{1'b1, 4'd9, 8'h0C, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 4'd9, 8'h00, 32'h0,        32'hFF00F000},  // R9 status write ignored
    '{1'b1, 4'd9, 8'h08, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 4'd9, 8'h04, 32'h0,        32'hFF00F000},  // R9 offset 8 write ignored
    '{1'b0, 4'd9, 8'h08, 32'h0,        32'h0},         // R9 offset 8 reads 0
    '{1'b1, 4'd4, 8'h14, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 4'd4, 8'h10, 32'h0,        32'h0},
    '{1'b1, 4'd2, 8'h10, 32'h00000081, 32'h0},
    '{1'b0, 4'd2, 8'h1C, 32'h0,        32'h00000081},  // R2 bank 1
    '{1'b0, 4'd2, 8'h00, 32'h0,        32'hFF00F000},  // R2 bank 0 untouched
    '{1'b1, 4'd2, 8'h40, 32'h00010000, 32'h0},
    '{1'b0, 4'd2, 8'h4C, 32'h0,        32'h00010000},  // R2 bank 4 lane 2
    '{1'b0, 4'd9, 8'h50, 32'h0,        32'h0},         // R9 missing bank
    '{1'b0, 4'd9, 8'h5C, 32'h0,        32'h0}          // R9 missing bank
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr_i = a; we_i = 1'b0;
    #1 chk(tag, rdata_o, exp);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    irq_i[31:0]    = 32'hA5A5F00F;
    irq_i[63:32]   = 32'h000000FF;
    irq_i[159:128] = 32'hFFFFFFFF;
    repeat (3) @(negedge clk_i);
    chk("R1 grp after reset", 32'(grp_irq_o), 32'h0);
    rst_ni = 1'b1;
    tick();
    chk("R1 grp inputs high, masked", 32'(grp_irq_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      addr_i = VECS[i].addr; wdata_i = VECS[i].data; we_i = VECS[i].we;
      #1;
      if (!VECS[i].we) begin
        n_chk++;
        if (rdata_o !== VECS[i].exp) begin
          n_bad++;
          $display("FAIL R%0d vec %0d addr %02h: actual %08h expected %08h",
                   VECS[i].req, i, VECS[i].addr, rdata_o, VECS[i].exp);
        end
      end
      tick();
      we_i = 1'b0;
    end

    // groups 1,3,4,18 pending and enabled
    chk("R6 group vector", 32'(grp_irq_o), 32'h0004001A);

    // R6: output follows input with one register stage
    irq_i[32] = 1'b0; irq_i[39] = 1'b0;
    #1 chk("R6 grp4 before edge", 32'(grp_irq_o[4]), 32'h1);
    tick();
    chk("R6 grp4 after edge", 32'(grp_irq_o[4]), 32'h0);
    irq_i[32] = 1'b1;
    #1 chk("R6 grp4 rise before edge", 32'(grp_irq_o[4]), 32'h0);
    tick();
    for (int k = 0; k < 3; k++) begin
      chk("R7 grp4 held while level high", 32'(grp_irq_o[4]), 32'h1);
      tick();
    end

    // masking through clear: output falls one cycle after the write edge
    wr(8'h14, 32'h00000001);
    chk("R7 grp4 at write edge", 32'(grp_irq_o[4]), 32'h1);
    addr_i = 8'h1C;
    #1 chk("R4 status after mask", rdata_o, 32'h0);
    tick();
    chk("R7 grp4 after mask", 32'(grp_irq_o[4]), 32'h0);

    // R1: reset mid-run with inputs high
    rst_ni = 1'b0;
    #1 chk("R1 async reset grp", 32'(grp_irq_o), 32'h0);
    tick();
    rst_ni = 1'b1;
    rd("R1 mask cleared", 8'h00, 32'h0);
    rd("R1 status cleared", 8'h4C, 32'h0);
    chk("R1 grp stays low", 32'(grp_irq_o), 32'h0);

    // R2: input 75 -> group 9 -> bank 2, lane 1, bit 3
    irq_i = '0;
    irq_i[75] = 1'b1;
    wr(8'h20, 32'h00000800);
    chk("R2 grp9 not yet", 32'(grp_irq_o), 32'h0);
    rd("R2 status bank2", 8'h2C, 32'h00000800);
    chk("R2 grp9 only", 32'(grp_irq_o), 32'h00000200);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule